// File: doc/BRIEF.md
# Signed Adder/Subtractor with Status Flags

This block is a purely combinational two's-complement adder for two operands of a parameterised width. It returns the result along with four status flags: carry out of the top bit, signed overflow, an all-zero result, and a negative result. A subtract control reuses the same adder to form the difference. It does this by inverting the right operand bit by bit and forcing the carry input high.

Carry handling uses a single widened addition. A pad bit is placed below the least significant bit of each operand. The left operand's pad is tied to 1 and the right operand's pad carries the effective carry input. A zero is placed above the most significant bit of each operand. The widened total therefore holds the carry-out in its top bit, and its pad bit is dropped. The flags are taken from this one result, so the block contains a single adder.

The block has no clock and no handshake. Every output follows its inputs within the same evaluation.

Top module: `signed_addsub_flags`

## Requirements
- R1: With `subtract`=0, `result` equals (`lhs` + `rhs` + `carry_in`) modulo 2^WIDTH.
- R2: With `subtract`=0, raising `carry_in` from 0 to 1 increases the result by exactly one, wrapping modulo 2^WIDTH.
- R3: With `subtract`=0, `carry_out` is bit WIDTH of the unsigned sum `lhs` + `rhs` + `carry_in`.
- R4: With `subtract`=1, `result` equals (`lhs` - `rhs`) modulo 2^WIDTH.
- R5: With `subtract`=1, `carry_in` has no effect on any output.
- R6: With `subtract`=1, `carry_out` is 1 exactly when `lhs` >= `rhs` as unsigned numbers, meaning no borrow occurred.
- R7: With `subtract`=0, `overflow` is 1 exactly when the signed sum falls outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. Example: 7+1 and -8+(-1) both overflow at WIDTH=4.
- R8: With `subtract`=1, `overflow` is 1 exactly when the signed difference `lhs` - `rhs` falls outside the signed range. Example: -8-1 and 7-(-1) both overflow at WIDTH=4.
- R9: `is_zero` is 1 exactly when every bit of `result` is 0.
- R10: `is_neg` equals bit WIDTH-1 of `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhs | input | WIDTH | Left operand, two's complement |
| rhs | input | WIDTH | Right operand, two's complement |
| carry_in | input | 1 | Carry input, used only when adding |
| subtract | input | 1 | 1 selects lhs - rhs, 0 selects lhs + rhs + carry_in |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit (no-borrow when subtracting) |
| overflow | output | 1 | Signed overflow |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Top bit of the result |

## Verification
Immediate assertions inside the design are evaluated whenever the inputs change. They compare the result, the carry-out and the overflow flag against an independently widened signed and unsigned reference. They also check that the zero and negative flags are never high together, and that the dropped pad bit always equals the inverse of the injected carry. The assertions cannot show that `carry_in` is ignored during subtraction, or that the carry input moves the result by exactly one. Those two properties come from the bench, which applies every operand pair in both modes with both carry values at WIDTH=4, including the extreme signed values. It compares each of the five outputs against an integer model.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic neg;
  } sadd_flags_t;
endpackage

// File: rtl/sadd_operand_prep.sv
module sadd_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rhs,
  input  logic             carry_in,
  input  logic             subtract,
  output logic [WIDTH-1:0] rhs_eff,
  output logic             cin_eff
);
  // Conditional bitwise inversion of the right operand
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign rhs_eff[i] = rhs[i] ^ subtract;
  end

  // Subtraction forces the +1; external carry is ignored then
  assign cin_eff = subtract | carry_in;
endmodule

// File: rtl/sadd_ext_adder.sv
module sadd_ext_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs_eff,
  input  logic             cin_eff,
  output logic [WIDTH-1:0] sum,
  output logic             carry
);
  localparam int EW = WIDTH + 2;

  logic [EW-1:0] ext_l;
  logic [EW-1:0] ext_r;
  logic [EW-1:0] wide;

  // Zero above the MSB collects the carry; pad below the LSB injects it
  assign ext_l = {1'b0, lhs, 1'b1};
  assign ext_r = {1'b0, rhs_eff, cin_eff};
  assign wide  = ext_l + ext_r;

  assign sum   = wide[WIDTH:1];
  assign carry = wide[EW-1];

  // The discarded pad bit is 1 + cin_eff, so its value is the inverse of the carry
  always_comb begin
    a_r2_pad_bit: assert (wide[0] == ~cin_eff)
      else $error("pad bit mismatch");
  end
endmodule

// File: rtl/sadd_flag_gen.sv
module sadd_flag_gen
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             lhs_msb,
  input  logic             rhs_msb,
  input  logic [WIDTH-1:0] sum,
  input  logic             carry,
  output sadd_flags_t      flags
);
  always_comb begin
    flags.carry = carry;
    // Like-signed inputs that produce an opposite-signed result
    flags.ovf   = (lhs_msb == rhs_msb) && (sum[WIDTH-1] != lhs_msb);
    flags.zero  = ~|sum;
    flags.neg   = sum[WIDTH-1];
  end

  always_comb begin
    a_r9_zero_not_neg: assert (!(flags.zero && flags.neg))
      else $error("zero and negative both set");
  end
endmodule

// File: rtl/signed_addsub_flags.sv
module signed_addsub_flags
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             carry_in,
  input  logic             subtract,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             is_zero,
  output logic             is_neg
);
  logic [WIDTH-1:0] rhs_eff;
  logic             cin_eff;
  logic [WIDTH-1:0] sum;
  logic             carry;
  sadd_flags_t      flags;

  sadd_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .rhs(rhs), .carry_in(carry_in), .subtract(subtract),
    .rhs_eff(rhs_eff), .cin_eff(cin_eff)
  );

  sadd_ext_adder #(.WIDTH(WIDTH)) u_add (
    .lhs(lhs), .rhs_eff(rhs_eff), .cin_eff(cin_eff),
    .sum(sum), .carry(carry)
  );

  // The overflow test sees the operand actually fed to the adder
  sadd_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .lhs_msb(lhs[WIDTH-1]), .rhs_msb(rhs_eff[WIDTH-1]),
    .sum(sum), .carry(carry), .flags(flags)
  );

  assign result    = sum;
  assign carry_out = flags.carry;
  assign overflow  = flags.ovf;
  assign is_zero   = flags.zero;
  assign is_neg    = flags.neg;

  // Independent reference arithmetic for the assertions
  logic signed [WIDTH:0] s_ref;
  logic        [WIDTH:0] u_ref;

  always_comb begin
    if (subtract) begin
      s_ref = $signed({lhs[WIDTH-1], lhs}) - $signed({rhs[WIDTH-1], rhs});
      u_ref = {1'b0, lhs} - {1'b0, rhs};
    end else begin
      s_ref = $signed({lhs[WIDTH-1], lhs}) + $signed({rhs[WIDTH-1], rhs})
              + $signed({{WIDTH{1'b0}}, carry_in});
      u_ref = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, carry_in};
    end

    a_r1_r4_result: assert (result == u_ref[WIDTH-1:0])
      else $error("result mismatch");
    a_r3_r6_carry: assert (carry_out == (subtract ? ~u_ref[WIDTH] : u_ref[WIDTH]))
      else $error("carry mismatch");
    a_r7_r8_overflow: assert (overflow == (s_ref[WIDTH] ^ s_ref[WIDTH-1]))
      else $error("overflow mismatch");
  end
endmodule

// File: tb/signed_addsub_flags_tb.sv
module signed_addsub_flags_tb;
  localparam int W = 4;

  typedef struct {
    int  a, b, ci, sb;
    int  sum;
    bit  cout, ovf, zero, neg;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] lhs = '0, rhs = '0;
  logic         carry_in = 1'b0, subtract = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, overflow, is_zero, is_neg;

  int tests = 0, fails = 0;
  bit finished = 0;
  item_t q[$];

  always #10 clk = ~clk;

  signed_addsub_flags #(.WIDTH(W)) u_dut (
    .lhs(lhs), .rhs(rhs), .carry_in(carry_in), .subtract(subtract),
    .result(result), .carry_out(carry_out), .overflow(overflow),
    .is_zero(is_zero), .is_neg(is_neg)
  );

  function automatic item_t model(int a, int b, int ci, int sb);
    item_t it;
    int sa, sbv, u, s;
    sa  = (a >= 8) ? a - 16 : a;
    sbv = (b >= 8) ? b - 16 : b;
    it.a = a; it.b = b; it.ci = ci; it.sb = sb;
    if (sb != 0) begin
      u = a - b; s = sa - sbv;
      it.cout = (a >= b);
    end else begin
      u = a + b + ci; s = sa + sbv + ci;
      it.cout = (u >= 16);
    end
    it.sum  = ((u % 16) + 16) % 16;
    it.ovf  = (s > 7) || (s < -8);
    it.zero = (it.sum == 0);
    it.neg  = (it.sum >= 8);
    return it;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp, item_t it);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d cin=%0d sub=%0d actual=%0d expected=%0d",
               req, it.a, it.b, it.ci, it.sb, act, exp);
    end
  endtask

  task automatic drive(int a, int b, int ci, int sb);
    @(posedge clk);
    lhs = a[W-1:0]; rhs = b[W-1:0];
    carry_in = ci[0]; subtract = sb[0];
    q.push_back(model(a, b, ci, sb));
  endtask

  // Monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        if (e.sb != 0) begin
          // R4 difference; R5 cin=1 must match the same model as cin=0
          chk(result == e.sum[W-1:0], (e.ci != 0) ? "R4 R5" : "R4", result, e.sum, e);
          chk(carry_out == e.cout, "R6", carry_out, e.cout, e);
          chk(overflow == e.ovf, "R8", overflow, e.ovf, e);
        end else begin
          // R1 sum; R2 carry-in adds exactly one
          chk(result == e.sum[W-1:0], (e.ci != 0) ? "R1 R2" : "R1", result, e.sum, e);
          chk(carry_out == e.cout, "R3", carry_out, e.cout, e);
          chk(overflow == e.ovf, "R7", overflow, e.ovf, e);
        end
        chk(is_zero == e.zero, "R9", is_zero, e.zero, e);
        chk(is_neg == e.neg, "R10", is_neg, e.neg, e);
      end
    end
  end

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Directed extremes first: R7 7+1, -8+-1; R8 -8-1, 7-(-1); R5 sub with cin
    drive(0, 0, 0, 0);
    drive(7, 1, 0, 0);
    drive(8, 15, 0, 0);
    drive(8, 1, 0, 1);
    drive(7, 15, 0, 1);
    drive(8, 8, 1, 1);
    drive(15, 1, 1, 0);
    // Exhaustive sweep
    for (int sb = 0; sb < 2; sb++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            drive(a, b, ci, sb);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", q.size());
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule